// File: doc/BRIEF.md
# Interrupt Distributor Control Register with Security Banking

This block is the top-level control register of an interrupt distributor. It holds three group-enable bits, a one-way security-disable flag, and a read-only view of the affinity-routing status. The rest of the distributor uses its outputs directly: the Group 0 enable, the non-secure Group 1 enable, the secure Group 1 enable and the security-disable flag.

Each write carries a security attribute. Which bits that write may change depends on the attribute and on whether security is already disabled. A read also carries a security attribute. While security is enabled, a non-secure read sees a reduced image of the register. Once security has been disabled, it stays disabled until reset. The act of disabling it clears the secure Group 1 enable and the non-secure routing status bit.

Register layout:

| Bit | Field | Notes |
|-----|-------|-------|
| 0 | Group 0 enable | |
| 1 | Non-secure Group 1 enable | |
| 2 | Secure Group 1 enable | |
| 3 | Wakeup enable | Always reads as zero |
| 4 | Non-secure routing status | Reads as 1 while security is enabled, 0 once it is disabled |
| 5 | Secure routing status | Always reads as 1 |
| 6 | Security-disable flag | |
| 7 to 30 | Reserved | Read as zero |
| 31 | Write-pending flag | Always reads as zero, because writes take effect immediately |

Top module: `dist_ctrl_reg`

## Requirements
- R1: After reset all three enables are 0 and the security-disable flag is 0. A secure read returns 0x00000030.
- R2: While the security-disable flag is 1, a write of either attribute changes only bits 0 and 1. All other written bits are ignored, and bit 2 stays 0.
- R3: While the security-disable flag is 0, a secure write loads bits 0, 1 and 2 from the write data and ignores bits 3 to 5 and 7 to 31.
- R4: A secure write with data bit 6 set, made while the flag is 0, sets the flag. In the same cycle it forces bit 2 to 0 and makes bit 4 read as 0.
- R5: Once set, the security-disable flag cannot be cleared by any write. Only reset clears it.
- R6: While the flag is 0, a non-secure write changes only bit 1. In particular it cannot set the flag.
- R7: While the flag is 0, a non-secure read returns bit 4 (always 1) and bit 1 of the secure view, with every other bit zero. While the flag is 1, both attributes read the full view.
- R8: In the full view, bit 5 is always 1, bit 4 is the inverse of the flag, bit 6 is the flag, and bits 3, 7 to 30 and 31 are 0. The enable outputs and the flag output equal bits 0, 1, 2 and 6 of the full view.
- R9: A cycle without a write strobe leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Write strobe, one write per cycle |
| wrSecure | input | 1 | Write carries the secure attribute |
| wrData | input | REG_W | Write data |
| rdSecure | input | 1 | Read carries the secure attribute |
| rdData | output | REG_W | Combinational read image for the given attribute |
| grp0En | output | 1 | Group 0 enable |
| grp1NsEn | output | 1 | Non-secure Group 1 enable |
| grp1SEn | output | 1 | Secure Group 1 enable |
| secDisabled | output | 1 | Security-disable flag |

## Verification
The assertions check the following on every cycle:
- the flag never falls once it has risen;
- a non-secure write under security leaves bits 0, 2 and the flag untouched;
- setting the flag clears the secure Group 1 enable;
- while the flag is set, the secure Group 1 enable stays low;
- the read image keeps its fixed bits and, for non-secure reads under security, its reduced mask.

Only the bench scenarios can show the exact values loaded by each kind of write: the ignored upper and reserved bits, the bit 2 clear that happens in the same write that sets the flag, and the return to the reset image.

// File: rtl/dctl_pkg.sv
package dctl_pkg;
  localparam int BIT_G0   = 0;
  localparam int BIT_G1NS = 1;
  localparam int BIT_G1S  = 2;
  localparam int BIT_RTNS = 4;
  localparam int BIT_RTS  = 5;
  localparam int BIT_SDIS = 6;
  localparam int BIT_PEND = 31;
  localparam int EN_W     = 3;

  typedef struct packed {
    logic [EN_W-1:0] wrMask;  // enable bits this write may load
    logic            setDis;  // this write disables security
    logic            nsView;  // the read returns the reduced image
  } ctlStrobes_t;
endpackage

// File: rtl/dctl_control.sv
module dctl_control
  import dctl_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             wrValid,
  input  logic             wrSecure,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdSecure,
  input  logic             disState,
  output ctlStrobes_t      strobes
);
  always_comb begin
    strobes = '0;
    if (wrValid) begin
      if (disState) begin
        strobes.wrMask = EN_W'(3'b011);
      end else if (wrSecure) begin
        strobes.wrMask = EN_W'(3'b111);
        strobes.setDis = wrData[BIT_SDIS];
      end else begin
        strobes.wrMask = EN_W'(3'b010);
      end
    end
    strobes.nsView = !rdSecure && !disState;
  end
endmodule

// File: rtl/dctl_datapath.sv
module dctl_datapath
  import dctl_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [REG_W-1:0] wrData,
  output logic             disState,
  output logic [EN_W-1:0]  enState,
  output logic [REG_W-1:0] rdData
);
  localparam logic [REG_W-1:0] NS_KEEP =
    (REG_W'(1) << BIT_PEND) | (REG_W'(1) << BIT_RTNS) | (REG_W'(1) << BIT_G1NS);

  logic [EN_W-1:0]  enNext;
  logic [REG_W-1:0] fullView;

  always_comb begin
    enNext = (enState & ~strobes.wrMask) | (wrData[EN_W-1:0] & strobes.wrMask);
    if (strobes.setDis) enNext[BIT_G1S] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enState  <= '0;
      disState <= 1'b0;
    end else begin
      enState  <= enNext;
      disState <= disState | strobes.setDis;
    end
  end

  always_comb begin
    fullView = '0;
    fullView[EN_W-1:0] = enState;
    fullView[BIT_RTNS] = !disState;
    fullView[BIT_RTS]  = 1'b1;
    fullView[BIT_SDIS] = disState;
    rdData = strobes.nsView ? (fullView & NS_KEEP) : fullView;
  end
endmodule

// File: rtl/dist_ctrl_reg.sv
module dist_ctrl_reg
  import dctl_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             wrSecure,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdSecure,
  output logic [REG_W-1:0] rdData,
  output logic             grp0En,
  output logic             grp1NsEn,
  output logic             grp1SEn,
  output logic             secDisabled
);
  ctlStrobes_t     strobes;
  logic            disState;
  logic [EN_W-1:0] enState;

  dctl_control #(.REG_W(REG_W)) i_control (
    .wrValid(wrValid), .wrSecure(wrSecure), .wrData(wrData),
    .rdSecure(rdSecure), .disState(disState), .strobes(strobes)
  );

  dctl_datapath #(.REG_W(REG_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .disState(disState), .enState(enState), .rdData(rdData)
  );

  assign grp0En      = enState[BIT_G0];
  assign grp1NsEn    = enState[BIT_G1NS];
  assign grp1SEn     = enState[BIT_G1S];
  assign secDisabled = disState;
endmodule

// File: rtl/dctl_checker.sv
module dctl_checker #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrValid,
  input logic             wrSecure,
  input logic [REG_W-1:0] wrData,
  input logic             rdSecure,
  input logic [REG_W-1:0] rdData,
  input logic             grp0En,
  input logic             grp1NsEn,
  input logic             grp1SEn,
  input logic             secDisabled
);
  p_dis_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    secDisabled |=> secDisabled);

  p_ns_write_bit1_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrSecure && !secDisabled) |=>
      ($stable(grp0En) && $stable(grp1SEn) && $stable(secDisabled)));

  p_dis_clears_g1s_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrSecure && !secDisabled && wrData[6]) |=> (secDisabled && !grp1SEn));

  p_dis_g1s_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    secDisabled |-> !grp1SEn);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> ($stable(grp0En) && $stable(grp1NsEn) && $stable(grp1SEn)));

  p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[31] && !rdData[3] && (rdData[5] == (rdSecure || secDisabled)));

  p_ns_view_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!rdSecure && !secDisabled) |->
      (((rdData & ~REG_W'(32'h8000_0012)) == '0) && rdData[4] && (rdData[1] == grp1NsEn)));
endmodule

bind dist_ctrl_reg dctl_checker #(.REG_W(REG_W)) i_checker (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrSecure(wrSecure), .wrData(wrData),
  .rdSecure(rdSecure), .rdData(rdData), .grp0En(grp0En), .grp1NsEn(grp1NsEn),
  .grp1SEn(grp1SEn), .secDisabled(secDisabled)
);

// File: tb/test_dist_ctrl_reg.sv
module test_dist_ctrl_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic        wrSecure = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdSecure = 1'b1;
  logic [31:0] rdData;
  logic        grp0En, grp1NsEn, grp1SEn, secDisabled;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  dist_ctrl_reg i_dist_ctrl_reg (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrSecure(wrSecure), .wrData(wrData),
    .rdSecure(rdSecure), .rdData(rdData), .grp0En(grp0En), .grp1NsEn(grp1NsEn),
    .grp1SEn(grp1SEn), .secDisabled(secDisabled)
  );

  typedef struct packed {
    logic        wv;
    logic        ws;
    logic [31:0] wd;
    logic        rs;
    logic [31:0] expRd;
    logic [3:0]  expSt;  // {grp1SEn, grp1NsEn, grp0En, secDisabled}
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 32'h0,        1'b1, 32'h30, 4'b0000},  // R1 reset image
    '{1'b1, 1'b1, 32'h7,        1'b1, 32'h37, 4'b1110},  // R3 secure sets enables
    '{1'b1, 1'b0, 32'h0,        1'b0, 32'h10, 4'b1010},  // R6 R7 ns clears bit1 only
    '{1'b1, 1'b0, 32'hFFFFFFFF, 1'b0, 32'h12, 4'b1110},  // R6 R7 ns sets bit1 only
    '{1'b0, 1'b0, 32'hFFFFFFFF, 1'b1, 32'h37, 4'b1110},  // R9 no strobe holds
    '{1'b1, 1'b1, 32'h1,        1'b1, 32'h31, 4'b0010},  // R3
    '{1'b1, 1'b1, 32'hFFFFFFB6, 1'b1, 32'h36, 4'b1100},  // R3 R8 reserved ignored
    '{1'b1, 1'b1, 32'h47,       1'b1, 32'h63, 4'b0111},  // R4 disable clears bit2, bit4
    '{1'b1, 1'b0, 32'h0,        1'b0, 32'h60, 4'b0001},  // R2 R7 full view after disable
    '{1'b1, 1'b1, 32'h0,        1'b1, 32'h60, 4'b0001},  // R5 flag not clearable
    '{1'b1, 1'b1, 32'hFFFFFFFF, 1'b1, 32'h63, 4'b0111},  // R2 bit2 not writable
    '{1'b1, 1'b0, 32'h1,        1'b0, 32'h61, 4'b0011}   // R2 ns writes bit0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic wv, input logic ws, input logic [31:0] wd, input logic rs);
    @(negedge clk);
    wrValid = wv; wrSecure = ws; wrData = wd; rdSecure = rs;
    @(posedge clk);
    #1 wrValid = 1'b0;
    #0.5;
  endtask

  initial begin
    #10000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wv, VECS[i].ws, VECS[i].wd, VECS[i].rs);
      check($sformatf("vector %0d read (R1-R9 table)", i), rdData, VECS[i].expRd);
      check($sformatf("vector %0d state R8", i),
            {28'd0, grp1SEn, grp1NsEn, grp0En, secDisabled}, {28'd0, VECS[i].expSt});
    end
    // R1: reset returns to the initial image
    @(negedge clk) rstN = 1'b0;
    #1 rdSecure = 1'b1;
    #0.5 check("R1 reset read", rdData, 32'h30);
    check("R1 reset state", {28'd0, grp1SEn, grp1NsEn, grp0En, secDisabled}, 32'h0);
    @(negedge clk) rstN = 1'b1;
    // R6: non-secure write cannot set the flag
    step(1'b1, 1'b0, 32'h47, 1'b0);
    check("R6 ns write ns read", rdData, 32'h12);
    check("R6 flag stays 0", {31'd0, secDisabled}, 32'h0);
    rdSecure = 1'b1;
    #0.5 check("R6 R8 secure read", rdData, 32'h32);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule